// File: doc/BRIEF.md
# SPI Peripheral Shifter with Select Suspend

This block is the peripheral (target) end of a four-wire SPI link, running on a fast system clock. The external serial clock, the active-low select and the incoming data line pass through a synchronizer. The block detects edges of the synchronized clock and shifts one bit on each valid edge. Both clock polarity and clock phase are chosen at run time.

On the transmit side there is a one-word holding register next to the shift register. Software can queue the next word while the current one is still shifting, so words follow each other with no idle clocks. On the receive side, each completed word is presented on a parallel output with a valid flag until software reads it. If select is released in the middle of a word, the block only pauses. The output enable drops, clock edges are ignored, and the bit position and both shift registers are kept, so the word continues from the same bit once select returns.

Top module: `spis_top`

## Requirements
- R1: While the synchronized select is inactive, `miso_oe_o` is low (output released) and `miso_o` is 0; `miso_oe_o` follows `cs_n_i` with exactly two system clocks of delay. Serial clock edges during that time change neither `tx_ready_o` nor `rx_valid_o`.
- R2: Releasing select mid-word keeps the bit position and both shift registers. After select returns, the word continues at the same bit and completes with the correct data in both directions.
- R3: `tx_ready_o` is 1 when the holding register is empty. A `tx_wr_i` pulse while ready stores `tx_data_i` and drops ready on the next cycle. A write while not ready is ignored and never transmitted. Ready rises again when the held word moves into the shifter.
- R4: A word queued in the holding register is sent immediately after the current word, with no extra serial clocks between the two.
- R5: The leading edge is the clock transition away from the `cpol_i` level. With `cpha_i`=0, data is sampled on leading edges and launched on trailing edges, and the first bit is driven as soon as select becomes active. With `cpha_i`=1, data is launched on leading edges and sampled on trailing edges.
- R6: Words are `WORD_W` bits long (2 to 16, default 8) and are shifted most significant bit first in both directions.
- R7: When the last bit of a word is sampled, the word appears on `rx_data_o` and `rx_valid_o` rises on the next cycle. Valid stays high until an `rx_rd_i` pulse clears it.
- R8: If the holding register is empty when a new word must be loaded, the previously loaded word is sent again and `underrun_o` is set and stays set. With `cpha_i`=1 the load happens at the first leading edge of the new word, and with `cpha_i`=0 it happens at select activation or at the trailing edge that ends the previous word.
- R9: If a word completes while `rx_valid_o` is still high and unread, `overrun_o` is set and stays set, and the newer word replaces the older one on `rx_data_o`.
- R10: A `flag_clr_i` pulse clears both sticky flags unless a new error sets one in the same cycle.
- R11: The serial clock may have any half period of at least four system clocks, and the half period may change within a word. `miso_o` changes no later than three system clocks after a launch edge.
- R12: After reset, `miso_oe_o`=0, `tx_ready_o`=1, `rx_valid_o`=0, `underrun_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for the `miso_o` pad driver |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edges, 1 samples on trailing edges |
| tx_data_i | input | WORD_W | Word to queue for transmission |
| tx_wr_i | input | 1 | Write strobe for `tx_data_i` |
| tx_ready_o | output | 1 | Holding register empty |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | Unread received word present |
| rx_rd_i | input | 1 | Acknowledge pulse that clears `rx_valid_o` |
| underrun_o | output | 1 | Sticky transmit underrun flag |
| overrun_o | output | 1 | Sticky receive overrun flag |
| flag_clr_i | input | 1 | Clears both sticky flags |

## Verification
Every cycle, the checker enforces these properties:
- the two-cycle link from select to the output enable;
- no completed word and no holding-register pop while deselected;
- write acceptance into an empty holding register;
- valid held until read;
- persistence of both sticky flags.

Only the scenarios can show the correct bit order in all four clock modes, resumption at the right bit after a pause, back-to-back queuing, replay of the last word on underrun, and replacement on overrun. The bench shows these by comparing whole serial words on both data lines against queued expectations.

// File: rtl/spis_pkg.sv
package spis_pkg;

   // Qualified serial events, already gated by the synchronized select.
   typedef struct packed {
      logic sample;   // edge on which the incoming bit is taken
      logic launch;   // edge on which the outgoing bit advances
      logic act;      // select active (synchronized)
      logic start;    // select just became active in phase-0 mode
      logic mosi;     // incoming data aligned with the clock pipeline
   } spis_evt_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync
   import spis_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sclk_i,
   input  logic      cs_n_i,
   input  logic      mosi_i,
   input  logic      cpol_i,
   input  logic      cpha_i,
   output spis_evt_t evt_o
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sclk_q;
   logic [STAGES-1:0] csn_q;
   logic [STAGES-1:0] mosi_q;
   logic              sclk_prev;
   logic              act_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q[0] <= 1'b0;
         csn_q[0]  <= 1'b1;
         mosi_q[0] <= 1'b0;
      end else begin
         sclk_q[0] <= sclk_i;
         csn_q[0]  <= cs_n_i;
         mosi_q[0] <= mosi_i;
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sclk_q[g] <= 1'b0;
            csn_q[g]  <= 1'b1;
            mosi_q[g] <= 1'b0;
         end else begin
            sclk_q[g] <= sclk_q[g-1];
            csn_q[g]  <= csn_q[g-1];
            mosi_q[g] <= mosi_q[g-1];
         end
      end
   end

   // The previous clock level is tracked even while deselected, so that
   // clock activity during a pause cannot appear as an edge on resume.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         act_prev  <= 1'b0;
      end else begin
         sclk_prev <= sclk_q[LAST];
         act_prev  <= ~csn_q[LAST];
      end
   end

   logic rise, fall, lead, trail, act;

   always_comb begin
      act   = ~csn_q[LAST];
      rise  = sclk_q[LAST] & ~sclk_prev;
      fall  = ~sclk_q[LAST] & sclk_prev;
      lead  = cpol_i ? fall : rise;
      trail = cpol_i ? rise : fall;
      evt_o.act    = act;
      evt_o.sample = act & (cpha_i ? trail : lead);
      evt_o.launch = act & (cpha_i ? lead : trail);
      evt_o.start  = act & ~act_prev & ~cpha_i;
      evt_o.mosi   = mosi_q[LAST];
   end

endmodule

// File: rtl/spis_txbuf.sv
module spis_txbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic         ready_o,
   output logic         full_o,
   output logic [W-1:0] data_o
);

   logic         full_q;
   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         word_q <= '0;
      end else if (pop_i && full_q) begin
         full_q <= 1'b0;
      end else if (wr_i && !full_q) begin
         full_q <= 1'b1;
         word_q <= data_i;
      end
   end

   assign ready_o = ~full_q;
   assign full_o  = full_q;
   assign data_o  = word_q;

endmodule

// File: rtl/spis_rxreg.sv
module spis_rxreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] word_i,
   input  logic         rd_i,
   output logic         valid_o,
   output logic [W-1:0] data_o,
   output logic         ovf_o
);

   logic         valid_q;
   logic [W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (push_i) begin
         valid_q <= 1'b1;
         data_q  <= word_i;
      end else if (rd_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
   assign ovf_o   = push_i & valid_q & ~rd_i;

endmodule

// File: rtl/spis_core.sv
module spis_core
   import spis_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  spis_evt_t    evt_i,
   input  logic         hold_full_i,
   input  logic [W-1:0] hold_data_i,
   output logic         pop_o,
   output logic         urun_o,
   output logic         rx_push_o,
   output logic [W-1:0] rx_word_o,
   output logic         miso_o,
   output logic         miso_oe_o
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   logic [W-1:0]  tx_sh;
   logic [W-1:0]  last_q;
   logic [W-2:0]  rx_sh;
   logic [CW-1:0] bit_cnt;
   logic          pend;
   logic          need_load;

   logic          last_bit;
   logic          do_load;
   logic [W-1:0]  load_word;
   logic [W-1:0]  rx_next;

   always_comb begin
      last_bit  = (bit_cnt == LAST_IDX);
      do_load   = need_load & (evt_i.launch | evt_i.start);
      load_word = hold_full_i ? hold_data_i : last_q;
      rx_next   = {rx_sh, evt_i.mosi};
   end

   // None of this state reacts to select going away: a paused word keeps
   // its position because no event is produced while deselected.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh     <= '0;
         last_q    <= '0;
         rx_sh     <= '0;
         bit_cnt   <= '0;
         pend      <= 1'b0;
         need_load <= 1'b1;
      end else begin
         if (do_load) begin
            tx_sh     <= load_word;
            last_q    <= load_word;
            need_load <= 1'b0;
            pend      <= 1'b0;
         end else if (evt_i.launch && pend) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
            pend  <= 1'b0;
         end
         if (evt_i.sample) begin
            rx_sh <= rx_next[W-2:0];
            pend  <= 1'b1;
            if (last_bit) begin
               bit_cnt   <= '0;
               need_load <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign pop_o     = do_load & hold_full_i;
   assign urun_o    = do_load & ~hold_full_i;
   assign rx_push_o = evt_i.sample & last_bit;
   assign rx_word_o = rx_next;
   assign miso_oe_o = evt_i.act;
   assign miso_o    = evt_i.act & tx_sh[W-1];

endmodule

// File: rtl/spis_top.sv
module spis_top
   import spis_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              cs_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic [WORD_W-1:0] tx_data_i,
   input  logic              tx_wr_i,
   output logic              tx_ready_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   input  logic              rx_rd_i,
   output logic              underrun_o,
   output logic              overrun_o,
   input  logic              flag_clr_i
);

   if (WORD_W < 2 || WORD_W > 16) begin : g_bad_width
      $error("spis_top: WORD_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spis_top: SYNC_STAGES must be at least 2");
   end

   spis_evt_t         evt;
   logic              hold_full;
   logic [WORD_W-1:0] hold_data;
   logic              pop;
   logic              urun_evt;
   logic              rx_push;
   logic [WORD_W-1:0] rx_word;
   logic              ovf_evt;
   logic              urun_q;
   logic              orun_q;

   spis_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk_i),
      .cs_n_i (cs_n_i),
      .mosi_i (mosi_i),
      .cpol_i (cpol_i),
      .cpha_i (cpha_i),
      .evt_o  (evt)
   );

   spis_txbuf #(.W(WORD_W)) u_txbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (tx_wr_i),
      .data_i  (tx_data_i),
      .pop_i   (pop),
      .ready_o (tx_ready_o),
      .full_o  (hold_full),
      .data_o  (hold_data)
   );

   spis_core #(.W(WORD_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .hold_full_i (hold_full),
      .hold_data_i (hold_data),
      .pop_o       (pop),
      .urun_o      (urun_evt),
      .rx_push_o   (rx_push),
      .rx_word_o   (rx_word),
      .miso_o      (miso_o),
      .miso_oe_o   (miso_oe_o)
   );

   spis_rxreg #(.W(WORD_W)) u_rxreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (rx_push),
      .word_i  (rx_word),
      .rd_i    (rx_rd_i),
      .valid_o (rx_valid_o),
      .data_o  (rx_data_o),
      .ovf_o   (ovf_evt)
   );

   // Sticky error flags: a new event wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         urun_q <= 1'b0;
         orun_q <= 1'b0;
      end else begin
         urun_q <= (urun_q & ~flag_clr_i) | urun_evt;
         orun_q <= (orun_q & ~flag_clr_i) | ovf_evt;
      end
   end

   assign underrun_o = urun_q;
   assign overrun_o  = orun_q;

endmodule

// File: rtl/spis_chk.sv
module spis_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n_i,
   input logic miso_oe_o,
   input logic tx_wr_i,
   input logic tx_ready_o,
   input logic rx_valid_o,
   input logic rx_rd_i,
   input logic underrun_o,
   input logic overrun_o,
   input logic flag_clr_i
);

   assert_hiz_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n_i, 2) |-> !miso_oe_o);

   assert_no_rx_while_paused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!miso_oe_o) |-> !$rose(rx_valid_o));

   assert_no_pop_while_paused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!miso_oe_o) |-> !$rose(tx_ready_o));

   assert_write_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_o && tx_wr_i |=> !tx_ready_o);

   assert_rx_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o && !rx_rd_i |=> rx_valid_o);

   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o && !flag_clr_i |=> underrun_o);

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o && !flag_clr_i |=> overrun_o);

endmodule

bind spis_top spis_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n_i     (cs_n_i),
   .miso_oe_o  (miso_oe_o),
   .tx_wr_i    (tx_wr_i),
   .tx_ready_o (tx_ready_o),
   .rx_valid_o (rx_valid_o),
   .rx_rd_i    (rx_rd_i),
   .underrun_o (underrun_o),
   .overrun_o  (overrun_o),
   .flag_clr_i (flag_clr_i)
);

// File: tb/sim_spis_top.sv
module sim_spis_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic         cs_n = 1'b1;
   logic         mosi = 1'b0;
   logic         cpol = 1'b0;
   logic         cpha = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic         tx_wr = 1'b0;
   logic         rx_rd = 1'b0;
   logic         flag_clr = 1'b0;
   logic         miso_o, miso_oe_o, tx_ready_o, rx_valid_o, underrun_o, overrun_o;
   logic [W-1:0] rx_data_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_en = 1'b1;
   logic [W-1:0] tx_q[$];
   logic [W-1:0] rx_q[$];

   always #2 clk = ~clk;

   spis_top #(.WORD_W(W)) u0 (
      .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .cs_n_i (cs_n), .mosi_i (mosi),
      .miso_o (miso_o), .miso_oe_o (miso_oe_o), .cpol_i (cpol), .cpha_i (cpha),
      .tx_data_i (tx_data), .tx_wr_i (tx_wr), .tx_ready_o (tx_ready_o),
      .rx_data_o (rx_data_o), .rx_valid_o (rx_valid_o), .rx_rd_i (rx_rd),
      .underrun_o (underrun_o), .overrun_o (overrun_o), .flag_clr_i (flag_clr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [W-1:0] d);
      tx_data = d;
      tx_wr   = 1'b1;
      @(negedge clk);
      tx_wr   = 1'b0;
   endtask

   task automatic clr_flags();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   // Deselect mid-word, wiggle the clock, then reselect (R1, R2).
   task automatic pause_sel();
      logic rdy, rv;
      wait_n(4);
      cs_n = 1'b1;
      wait_n(6);
      check("R1 output released", miso_oe_o, 1'b0);
      check("R1 data low", miso_o, 1'b0);
      rdy = tx_ready_o;
      rv  = rx_valid_o;
      for (int k = 0; k < 4; k++) begin
         sclk = ~sclk;
         wait_n(4);
      end
      check("R1 ready untouched", tx_ready_o, rdy);
      check("R1 valid untouched", rx_valid_o, rv);
      cs_n = 1'b0;
      wait_n(6);
   endtask

   // One controller word; bit 3 uses a longer half period (R11).
   task automatic xfer(input logic [W-1:0] mo, input int h, input int split);
      logic [W-1:0] got;
      logic [W-1:0] exp;
      got = '0;
      if (mon_en) rx_q.push_back(mo);
      for (int i = W - 1; i >= 0; i--) begin
         int hb;
         hb = (i == 3) ? h + 3 : h;
         if (!cpha) begin
            mosi = mo[i];
            wait_n(hb);
            got[i] = miso_o;
            sclk = ~sclk;
            wait_n(hb);
            sclk = ~sclk;
         end else begin
            sclk = ~sclk;
            mosi = mo[i];
            wait_n(hb);
            got[i] = miso_o;
            sclk = ~sclk;
            wait_n(hb);
         end
         if (i == split) pause_sel();
      end
      exp = tx_q.pop_front();
      check("R6 R5 serial word out", got, exp);
   endtask

   task automatic begin_sel();
      cs_n = 1'b0;
      wait_n(6);
   endtask

   task automatic end_sel();
      wait_n(6);
      cs_n = 1'b1;
      wait_n(6);
   endtask

   // Monitor: pops the expected received word whenever one is presented (R7).
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en && rx_valid_o) begin
            if (rx_q.size() == 0) check("R7 unexpected word", rx_data_o, 32'hdead);
            else check("R7 received word", rx_data_o, rx_q.pop_front());
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      // R12 reset state
      check("R12 oe", miso_oe_o, 1'b0);
      check("R12 ready", tx_ready_o, 1'b1);
      check("R12 valid", rx_valid_o, 1'b0);
      check("R12 underrun", underrun_o, 1'b0);
      check("R12 overrun", overrun_o, 1'b0);

      // Mode 0: queue, ignored write, back-to-back (R3, R4, R5)
      cpol = 1'b0; cpha = 1'b0; sclk = 1'b0;
      wr(8'hA5); tx_q.push_back(8'hA5);
      check("R3 ready drops on write", tx_ready_o, 1'b0);
      wr(8'h77);  // ignored: holding register full
      begin_sel();
      check("R1 output driven when selected", miso_oe_o, 1'b1);
      check("R3 ready after load", tx_ready_o, 1'b1);
      wr(8'h3E); tx_q.push_back(8'h3E);
      xfer(8'h3C, 4, -1);
      xfer(8'hC3, 4, -1);
      end_sel();
      check("R8 underrun after last trailing edge", underrun_o, 1'b1);
      check("R9 no overrun", overrun_o, 1'b0);
      clr_flags();
      check("R10 cleared", underrun_o, 1'b0);
      tx_q.push_back(8'h3E);  // replayed word is already in the shifter

      // Mode 3 with a pause mid-word (R2, R5)
      cpol = 1'b1; sclk = 1'b1; cpha = 1'b1;
      wait_n(6);
      wr(8'h69); tx_q.push_back(8'h69);
      begin_sel();
      xfer(8'h96, 5, 4);
      xfer(8'h1F, 5, -1);
      end_sel();
      check("R8 no underrun when session ends in phase 1", underrun_o, 1'b0);

      // Mode 1: refill during a word, then underrun (R4, R8, R10)
      cpol = 1'b0; sclk = 1'b0; cpha = 1'b1;
      wait_n(6);
      wr(8'hD2); tx_q.push_back(8'hD2);
      tx_q.push_back(8'h4B); tx_q.push_back(8'h4B);
      begin_sel();
      fork
         begin wait_n(30); wr(8'h4B); end
      join_none
      xfer(8'h81, 4, -1);
      xfer(8'h5A, 4, -1);
      xfer(8'hE7, 4, -1);
      end_sel();
      check("R8 underrun replays last word", underrun_o, 1'b1);
      clr_flags();
      check("R10 underrun cleared", underrun_o, 1'b0);

      // Mode 2 with a pause and slower clock (R2, R5, R11)
      cpol = 1'b1; sclk = 1'b1; cpha = 1'b0;
      wait_n(6);
      wr(8'hF0); tx_q.push_back(8'hF0);
      begin_sel();
      xfer(8'h2D, 6, 5);
      end_sel();
      clr_flags();

      // Overrun: two words without reading (R7, R9)
      cpol = 1'b0; sclk = 1'b0; cpha = 1'b0;
      wait_n(6);
      mon_en = 1'b0;
      tx_q.push_back(8'hF0);
      wr(8'h0C); tx_q.push_back(8'h0C);
      begin_sel();
      xfer(8'h11, 4, -1);
      xfer(8'hB4, 4, -1);
      end_sel();
      check("R7 valid held while unread", rx_valid_o, 1'b1);
      check("R9 overrun set", overrun_o, 1'b1);
      check("R9 newer word kept", rx_data_o, 8'hB4);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      check("R7 valid cleared by read", rx_valid_o, 1'b0);
      clr_flags();
      check("R10 overrun cleared", overrun_o, 1'b0);
      check("R7 all words seen", rx_q.size(), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule